// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Store Drain Queue

This block sits between a processor load/store port and a slower single-word memory port. It keeps one 32-bit word per line in a direct-mapped array. Loads that find their word return it on the next cycle. Loads that do not find it hold the processor off, fetch the word from memory, install it and return it.

Stores never wait for memory. Each accepted store is placed in a small in-order queue, and a memory-side engine writes the queued words out one at a time. A store whose line is present also updates that line. A store whose line is absent is not allocated, and the line at that index is invalidated instead. Before a load miss goes to memory, the queue is emptied. This ensures that a fetch always sees every earlier store.

Every accepted access produces exactly one response pulse, and that pulse carries a hit/miss flag. Loads are accepted back to back while they hit. Stores are accepted back to back while the queue has room.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is high, `mem_req` is low and `cpu_rsp_valid` is low, so the first load to any address misses.
- R2: The line index is address bits [IDX_W+1:2] with IDX_W = log2(LINES), and the tag is the bits above them. Address bits [1:0] take no part in lookup. Every memory request carries a word-aligned address, with bits [1:0] equal to 0.
- R3: A load that hits is answered in the cycle after acceptance with `cpu_rsp_hit`=1 and the stored word. It issues no memory request, and `cpu_req_ready` stays high.
- R4: A load that misses drops `cpu_req_ready` until the fill completes. It issues one memory read of the word address, installs the returned word with its tag, and answers with `cpu_rsp_hit`=0 and that word in the cycle after `mem_ack`.
- R5: Every accepted store is written to memory in acceptance order as a request with `mem_we`=1, its word address and its data. The memory request and its fields stay steady until `mem_ack`. A store is answered in the cycle after acceptance with `cpu_rsp_rdata`=0 and `cpu_rsp_hit` equal to its lookup result.
- R6: A store that hits updates the cached word, so a later load of that address hits and returns the new data.
- R7: A store that misses allocates nothing and invalidates the line at its index, so the next load of any address at that index misses.
- R8: A store is held off (`cpu_req_ready` low) only when the queue holds WB_DEPTH entries. No entry is ever added to a full queue.
- R9: A load-miss read reaches the memory port only when the store queue is empty. Pending queued writes therefore always go first.
- R10: Each accepted access produces exactly one single-cycle `cpu_rsp_valid` pulse, and responses come in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_hit | output | 1 | Lookup hit flag for the response |
| cpu_rsp_rdata | output | 32 | Load data, zero for stores |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench builds the cache with LINES = 16 and WB_DEPTH = 4. With only 16 lines, addresses 16 words apart collide, so ping-pong conflicts, store-miss invalidation and reloads all occur within a few hundred accesses over a 64-word address range. A memory latency of up to six cycles, together with bursts of stores, fills the four-entry queue. This exercises the full-queue stall and the wait for the queue to empty before a load-miss fetch.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FETCH = 2'd2
  } ctl_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wb_entry_t;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store
  import wtc_pkg::*;
#(
  parameter int LINES = 1024,
  parameter int TAG_W = 20,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // Per-line valid bit with its own set/clear enables
  for (genvar g = 0; g < LINES; g++) begin : g_valid
    logic set_l, clr_l;
    assign set_l = wr_en  && (wr_idx  == IDX_W'(g));
    assign clr_l = inv_en && (inv_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q[g] <= 1'b0;
      else if (set_l) valid_q[g] <= 1'b1;
      else if (clr_l) valid_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf
  import wtc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t push_ent,
  input  logic      pop,
  output wb_entry_t head,
  output logic      empty,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wb_entry_t           slot_q [DEPTH];
  logic [PTR_W-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_ent;
  end

  assign head  = slot_q[rd_ptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/wtc_mem_port.sv
module wtc_mem_port
  import wtc_pkg::*;
(
  input  logic              wb_empty,
  input  wb_entry_t         wb_head,
  input  logic              fetch_active,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wb_pop,
  output logic              fill_done
);
  // Queued writes always win the port over a fill fetch
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    wb_pop    = 1'b0;
    fill_done = 1'b0;
    if (!wb_empty) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = wb_head.addr;
      mem_wdata = wb_head.data;
      wb_pop    = mem_ack;
    end else if (fetch_active) begin
      mem_req   = 1'b1;
      mem_addr  = fetch_addr;
      fill_done = mem_ack;
    end
  end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wtc_pkg::*;
#(
  parameter int LINES    = 1024,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  ctl_state_e        state_q, state_d;
  logic [IDX_W-1:0]  lk_idx, miss_idx_q;
  logic [TAG_W-1:0]  lk_tag, miss_tag_q;
  logic              ln_valid;
  logic [TAG_W-1:0]  ln_tag;
  logic [DATA_W-1:0] ln_data;
  logic              lk_hit, accept, store_hit, store_miss, miss_start;
  logic              wb_empty, wb_full, wb_push, wb_pop, fill_done;
  wb_entry_t         wb_head, wb_in;
  logic              rsp_valid_d, rsp_hit_d;
  logic [DATA_W-1:0] rsp_data_d;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  assign lk_idx = cpu_req_addr[IDX_W+OFS_W-1:OFS_W];
  assign lk_tag = cpu_req_addr[ADDR_W-1:IDX_W+OFS_W];
  assign lk_hit = ln_valid && (ln_tag == lk_tag);

  assign cpu_req_ready = (state_q == ST_IDLE) && !(cpu_req_we && wb_full);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign store_hit     = accept &&  cpu_req_we &&  lk_hit;
  assign store_miss    = accept &&  cpu_req_we && !lk_hit;
  assign miss_start    = accept && !cpu_req_we && !lk_hit;
  assign wb_push       = accept &&  cpu_req_we;
  assign wb_in.addr    = {cpu_req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign wb_in.data    = cpu_req_wdata;

  always_comb begin
    wr_en   = store_hit || fill_done;
    wr_idx  = fill_done ? miss_idx_q : lk_idx;
    wr_tag  = fill_done ? miss_tag_q : lk_tag;
    wr_data = fill_done ? mem_rdata  : cpu_req_wdata;
  end

  wtc_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_lines (
    .clk(clk), .rst_n(rst_core_n),
    .rd_idx(lk_idx), .rd_valid(ln_valid), .rd_tag(ln_tag), .rd_data(ln_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .inv_en(store_miss), .inv_idx(lk_idx)
  );

  wtc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_core_n),
    .push(wb_push), .push_ent(wb_in), .pop(wb_pop),
    .head(wb_head), .empty(wb_empty), .full(wb_full)
  );

  wtc_mem_port u_mport (
    .wb_empty(wb_empty), .wb_head(wb_head),
    .fetch_active(state_q == ST_FETCH),
    .fetch_addr({miss_tag_q, miss_idx_q, {OFS_W{1'b0}}}),
    .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wb_pop(wb_pop), .fill_done(fill_done)
  );

  // Control next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (miss_start) state_d = ST_DRAIN;
      ST_DRAIN: if (wb_empty)   state_d = ST_FETCH;
      ST_FETCH: if (fill_done)  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  // Response next state
  always_comb begin
    rsp_valid_d = (accept && (cpu_req_we || lk_hit)) || fill_done;
    rsp_hit_d   = fill_done ? 1'b0 : lk_hit;
    if (fill_done)       rsp_data_d = mem_rdata;
    else if (cpu_req_we) rsp_data_d = '0;
    else                 rsp_data_d = ln_data;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q       <= ST_IDLE;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_hit   <= 1'b0;
    end else begin
      state_q       <= state_d;
      cpu_rsp_valid <= rsp_valid_d;
      cpu_rsp_hit   <= rsp_hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) cpu_rsp_rdata <= rsp_data_d;
  end

  always_ff @(posedge clk) begin
    if (miss_start) begin
      miss_idx_q <= lk_idx;
      miss_tag_q <= lk_tag;
    end
  end
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
  import wtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              wb_empty,
  input logic              wb_full,
  input logic              wb_push
);
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r4_stall_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !cpu_req_ready);

  a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wb_push |-> !wb_full);

  a_r9_fetch_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> wb_empty);

  a_r10_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> ($past(cpu_req_valid && cpu_req_ready) || $past(mem_req && mem_ack && !mem_we)));
endmodule

bind wt_dcache wtc_checker u_chk (
  .clk(clk), .rst_n(rst_core_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .wb_empty(wb_empty), .wb_full(wb_full), .wb_push(wb_push)
);

// File: tb/wt_dcache_tb.sv
module wt_dcache_tb;
  localparam int LINES = 16;
  localparam int DEPTH = 4;
  localparam int IDXB  = $clog2(LINES);

  logic clk, rst_n;
  logic cpu_req_valid, cpu_req_ready, cpu_req_we;
  logic [31:0] cpu_req_addr, cpu_req_wdata;
  logic cpu_rsp_valid, cpu_rsp_hit;
  logic [31:0] cpu_rsp_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  wt_dcache #(.LINES(LINES), .WB_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference state
  logic [31:0] golden   [int unsigned];
  logic [31:0] mem_arr  [int unsigned];
  bit          ref_vld  [LINES];
  logic [31:0] ref_tag  [LINES];
  logic [31:0] exp_wa[$], exp_wd[$];
  logic [32:0] exp_rsp[$];            // {hit, data}
  int          op_kind[$];            // 0 load, 1 store, 2 idle
  logic [31:0] op_addr[$], op_data[$];
  int          wcount = 0;
  bit          busy = 0;
  logic [31:0] miss_word;
  int          lat = 2, lat_cnt = 0;
  logic [31:0] lfsr = 32'hACE1_2345;

  function automatic logic [31:0] init_word(input logic [31:0] wa);
    return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] gold_rd(input logic [31:0] wa);
    return golden.exists(wa) ? golden[wa] : init_word(wa);
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] wa);
    return mem_arr.exists(wa) ? mem_arr[wa] : init_word(wa);
  endfunction

  task automatic next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic add_op(input int k, input logic [31:0] word, input logic [31:0] d, input logic [1:0] lo);
    op_kind.push_back(k);
    op_addr.push_back({word[29:0], lo});
    op_data.push_back(d);
  endtask

  initial begin
    bit have_op = 0;
    int cycles = 0;
    bit acc, wack, rack, exp_rdy;
    logic [31:0] wa, tg;
    int ix;
    logic [32:0] e;

    cpu_req_valid = 0; cpu_req_we = 0; cpu_req_addr = 0; cpu_req_wdata = 0;
    mem_ack = 0; mem_rdata = 0;
    for (int i = 0; i < LINES; i++) begin ref_vld[i] = 0; ref_tag[i] = 0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #5;
    chk(cpu_req_ready == 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 1);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);
    chk(cpu_rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(cpu_rsp_valid), 0);

    // R1/R3/R4: classic trace; first loads miss, repeats hit
    foreach (op_kind[i]) ;
    add_op(0, 0, 0, 2'b00); add_op(0, 1, 0, 2'b01); add_op(0, 2, 0, 2'b10);
    add_op(0, 3, 0, 2'b11); add_op(0, 4, 0, 2'b00); add_op(0, 3, 0, 2'b00);
    add_op(0, 4, 0, 2'b10); add_op(0, 15, 0, 2'b00);
    // R2: ping-pong on one index
    add_op(0, 16, 0, 0); add_op(0, 0, 0, 0); add_op(0, 16, 0, 0); add_op(2, 0, 0, 0);
    // R6: store hit then load hit; R7: store miss invalidates, reload misses
    add_op(1, 1, 32'hCAFE_0001, 2'b10); add_op(0, 1, 0, 0);
    add_op(1, 17, 32'hBEEF_0017, 0); add_op(0, 1, 0, 0); add_op(0, 17, 0, 0);
    // R8/R9: store burst to fill queue, then a load miss behind it
    for (int i = 0; i < 7; i++) add_op(1, 32 + i, 32'h1000_0000 + i, 0);
    add_op(0, 40, 0, 0); add_op(0, 33, 0, 0);
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      next_rand();
      if (lfsr[3:0] == 0) add_op(2, 0, 0, 0);
      else add_op(lfsr[4] & lfsr[5] ? 1 : 0, {26'd0, lfsr[13:8]}, lfsr ^ 32'h0F0F_3C3C, lfsr[7:6]);
    end

    while (cycles < 60000 && (op_kind.size() > 0 || have_op || busy ||
           exp_rsp.size() > 0 || exp_wa.size() > 0)) begin
      @(negedge clk);
      cycles++;
      // memory side
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        lat_cnt++;
        if (lat_cnt >= lat) begin
          mem_ack = 1; lat_cnt = 0;
          mem_rdata = mem_rd(mem_addr >> 2);
        end
      end else lat_cnt = 0;
      // processor side
      if (!have_op && op_kind.size() > 0) begin
        int k;
        k = op_kind.pop_front();
        cpu_req_addr  = op_addr.pop_front();
        cpu_req_wdata = op_data.pop_front();
        if (k == 2) begin cpu_req_valid = 0; cpu_req_we = 0; end
        else begin cpu_req_valid = 1; cpu_req_we = (k == 1); have_op = 1; end
        if (cycles > 120) begin next_rand(); lat = 1 + int'(lfsr[2:0] % 6); end
      end else if (!have_op) cpu_req_valid = 0;
      #5;
      // response pulse
      if (cpu_rsp_valid) begin
        if (exp_rsp.size() == 0) chk(0, "R10", "unexpected response", 1, 0);
        else begin
          e = exp_rsp.pop_front();
          chk(cpu_rsp_hit == e[32], "R10", "hit flag", 32'(cpu_rsp_hit), 32'(e[32]));
          chk(cpu_rsp_rdata == e[31:0], "R3", "response data", cpu_rsp_rdata, e[31:0]);
        end
      end
      if (cpu_req_valid) begin
        exp_rdy = !busy && !(cpu_req_we && wcount == DEPTH);
        chk(cpu_req_ready == exp_rdy, cpu_req_we ? "R8" : "R4", "ready", 32'(cpu_req_ready), 32'(exp_rdy));
      end
      acc  = cpu_req_valid && cpu_req_ready;
      wack = mem_req && mem_ack && mem_we;
      rack = mem_req && mem_ack && !mem_we;
      if (mem_req) chk(mem_addr[1:0] == 2'b00, "R2", "mem address alignment", mem_addr, {mem_addr[31:2], 2'b00});
      if (wack) begin
        if (exp_wa.size() == 0) chk(0, "R5", "unexpected memory write", mem_addr, 0);
        else begin
          wa = exp_wa.pop_front();
          chk(mem_addr == wa, "R5", "write order address", mem_addr, wa);
          chk(mem_wdata == exp_wd[0], "R5", "write data", mem_wdata, exp_wd[0]);
          void'(exp_wd.pop_front());
        end
        mem_arr[mem_addr >> 2] = mem_wdata;
        wcount--;
      end
      if (rack) begin
        chk(exp_wa.size() == 0, "R9", "queue empty at fetch", exp_wa.size(), 0);
        chk(busy, "R4", "read only after a load miss", 32'(busy), 1);
        chk(mem_addr == {miss_word[29:0], 2'b00}, "R4", "fetch address", mem_addr, {miss_word[29:0], 2'b00});
        busy = 0;
      end
      if (acc) begin
        wa = cpu_req_addr >> 2;
        ix = int'(wa % LINES);
        tg = wa >> IDXB;
        have_op = 0;
        if (cpu_req_we) begin
          // R6 / R7: hit updates the line, miss invalidates it
          if (!(ref_vld[ix] && ref_tag[ix] == tg)) ref_vld[ix] = 0;
          exp_rsp.push_back({ref_vld[ix] && ref_tag[ix] == tg, 32'h0});
          golden[wa] = cpu_req_wdata;
          exp_wa.push_back({wa[29:0], 2'b00});
          exp_wd.push_back(cpu_req_wdata);
          wcount++;
        end else if (ref_vld[ix] && ref_tag[ix] == tg) begin
          exp_rsp.push_back({1'b1, gold_rd(wa)});
        end else begin
          exp_rsp.push_back({1'b0, gold_rd(wa)});
          ref_vld[ix] = 1; ref_tag[ix] = tg;
          busy = 1; miss_word = wa;
        end
      end
    end
    @(negedge clk); #5;
    chk(cpu_rsp_valid == 1'b0, "R10", "no trailing pulse", 32'(cpu_rsp_valid), 0);
    chk(mem_req == 1'b0, "R5", "queue drained at end", 32'(mem_req), 0);
    if (cycles >= 60000) chk(0, "R10", "watchdog expired", cycles, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule